// File: doc/BRIEF.md
# Cascadable LCD Segment Driver Datapath

This block is the digital core of an 80-column dot-matrix LCD driver. Display data arrives four bits at a time, qualified by a slow shift clock. Twenty accepted nibbles fill a 4-wide, 20-deep shift register. The direction of that register is selectable. A falling edge on a load strobe copies the register into an 80-bit latch. Every latched bit is then turned into a 2-bit drive-level code. The code depends on the bit, a frame-alternation input and an active-low blanking input. The analog side turns each code into one of four bias voltages.

Several drivers can share one nibble bus. A pair of enable pins passes the right to accept data down a chain. The direction input decides which pin of the pair receives and which pin passes. A driver arms when its receiving pin is low. It accepts exactly twenty nibbles, then pulses its passing pin low for one clock. After that it stays deaf to the shift clock until the next load strobe.

The shift clock and the load strobe are sampled in the system clock domain and acted on at their falling edges. The system clock must therefore run well above both strobes.

Top module: `lcdseg_driver`

## Requirements
- R1: After the synchronous active-high reset, the latch holds all zeros. The enable logic is idle, and both enable outputs are high. With alternation low and blanking high, every output code is 2'b01.
- R2: While the driver is armed, each falling edge of the shift clock enters the nibble on the data input into the register. The edge is seen at the first system clock edge that samples the shift clock low after it was high.
- R3: While the driver is not armed, shift-clock edges leave the register unchanged. A later load shows this at the outputs.
- R4: With direction low, nibble k of a 20-nibble fill (k = 0 first) lands on output indices 4*(19-k) .. 4*(19-k)+3. Its bit b goes to output index 4*(19-k)+b, where output index j is code bits [2j+1:2j].
- R5: With direction high, nibble k lands on output indices 4*k .. 4*k+3. Its bit b goes to output index 4*k+3-b, so the last nibble's bit 0 is on output index 79.
- R6: With direction low, the right enable input arms the driver and the left enable output passes enable on. The right enable output is held high. With direction high the two roles are swapped, and the left enable input has no effect on arming when direction is low (and the right one none when high).
- R7: On the 20th accepted nibble, the passing enable output goes low for exactly one system clock cycle. Further shift-clock edges are then ignored until the next load, even while the receiving input stays low.
- R8: A falling load edge copies the register into the latch. The latch holds its value otherwise, including while new nibbles are shifted in. A load also disarms the driver. It re-arms only when its receiving enable input is low.
- R9: With blanking high, output code j is 2'b01 for alternation 0 and bit 0, 2'b00 for alternation 0 and bit 1, 2'b10 for alternation 1 and bit 0, and 2'b11 for alternation 1 and bit 1.
- R10: With blanking low, every output code is 2'b00, whatever the latch and the alternation input hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk_i | input | 1 | Nibble shift clock, acted on at its falling edge |
| nibble_i | input | 4 | Display data nibble |
| load_i | input | 1 | Latch strobe, acted on at its falling edge |
| dir_i | input | 1 | Shift direction and enable pin role select |
| en_right_i | input | 1 | Right enable input, active low (receives when dir_i is low) |
| en_left_i | input | 1 | Left enable input, active low (receives when dir_i is high) |
| en_right_o | output | 1 | Right enable output (passes when dir_i is high, else high) |
| en_left_o | output | 1 | Left enable output (passes when dir_i is low, else high) |
| alt_i | input | 1 | Frame alternation select |
| blank_n_i | input | 1 | Blanking, active low |
| level_o | output | 160 | Packed 2-bit drive-level codes, output j at bits [2j+1:2j] |

## Verification
The assertions check several rules on every cycle. The handoff pulse always lasts exactly one cycle and leaves the driver spent. The nibble counter never leaves its range. A shift edge that arrives while the driver is not armed leaves the register untouched. The latch changes only on a load edge, and then it equals the register. A blanked bus is all zeros.

Other properties can only be shown by the bench's scenarios. These are the placement of each nibble in both directions, the full level encoding, and the swapped roles of the enable pins. The same holds for the refusal to re-arm after a load while the receiving input is high.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

    // Drive-level codes handed to the analog output stage.
    typedef enum logic [1:0] {
        LVL_V1  = 2'b00,
        LVL_V3  = 2'b01,
        LVL_V4  = 2'b10,
        LVL_VEE = 2'b11
    } drive_lvl_e;

    // Enable chain state: waiting for the receiving pin, taking nibbles,
    // or finished until the next load strobe.
    typedef enum logic [1:0] {
        EN_IDLE  = 2'b00,
        EN_ARMED = 2'b01,
        EN_SPENT = 2'b10
    } en_state_e;

    // Per-frame output controls shared by every column.
    typedef struct packed {
        logic alt;
        logic blank_n;
    } frame_ctl_t;

    // Pick the drive level for one column.
    function automatic drive_lvl_e pick_level(input logic data_bit, input frame_ctl_t ctl);
        drive_lvl_e lvl;
        if (!ctl.blank_n) begin
            lvl = LVL_V1;
        end else if (ctl.alt) begin
            lvl = data_bit ? LVL_VEE : LVL_V4;
        end else begin
            lvl = data_bit ? LVL_V1 : LVL_V3;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/lcdseg_fall_det.sv
module lcdseg_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_i;
        end
    end

    assign fall_o = sig_q & ~sig_i;

endmodule

// File: rtl/lcdseg_chain_ctl.sv
module lcdseg_chain_ctl
    import lcdseg_pkg::*;
#(
    parameter int GROUPS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_i,
    input  logic load_fall_i,
    input  logic shift_fall_i,
    input  logic en_right_i,
    input  logic en_left_i,
    output logic en_right_o,
    output logic en_left_o,
    output logic accept_o
);
    localparam int CNT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GROUPS - 1);

    en_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             handoff_q;
    logic             recv_n;
    logic             pass_n;

    // Receiving pin follows the direction.
    assign recv_n   = dir_i ? en_left_i : en_right_i;
    assign accept_o = (state_q == EN_ARMED) && shift_fall_i && !load_fall_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= EN_IDLE;
            cnt_q     <= '0;
            handoff_q <= 1'b0;
        end else begin
            handoff_q <= 1'b0;
            if (load_fall_i) begin
                state_q <= EN_IDLE;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    EN_IDLE: begin
                        if (!recv_n) begin
                            state_q <= EN_ARMED;
                        end
                    end
                    EN_ARMED: begin
                        if (accept_o) begin
                            if (cnt_q == LAST_CNT) begin
                                state_q   <= EN_SPENT;
                                cnt_q     <= '0;
                                handoff_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        state_q <= EN_SPENT;
                    end
                endcase
            end
        end
    end

    // Passing pin pulses low for one cycle; the receiving side's output idles high.
    assign pass_n     = ~handoff_q;
    assign en_left_o  = dir_i ? 1'b1 : pass_n;
    assign en_right_o = dir_i ? pass_n : 1'b1;

    a_r7_handoff_one_cycle: assert property (@(posedge clk) disable iff (rst)
        handoff_q |=> !handoff_q);

    a_r7_spent_after_handoff: assert property (@(posedge clk) disable iff (rst)
        handoff_q |-> (state_q == EN_SPENT));

    a_r7_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);

    a_r8_load_disarms: assert property (@(posedge clk) disable iff (rst)
        load_fall_i |=> (state_q == EN_IDLE));

endmodule

// File: rtl/lcdseg_shifter.sv
module lcdseg_shifter #(
    parameter int NIB_W  = 4,
    parameter int GROUPS = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en_i,
    input  logic                      dir_i,
    input  logic [NIB_W-1:0]          nib_i,
    output logic [NIB_W*GROUPS-1:0]   sreg_o
);
    localparam int TOP = GROUPS - 1;

    logic [GROUPS-1:0][NIB_W-1:0] grp_q;
    logic [NIB_W-1:0]             nib_rev;

    // Mirrored entry: bit order reversed when filling from the high end.
    for (genvar b = 0; b < NIB_W; b++) begin : g_rev
        assign nib_rev[b] = nib_i[NIB_W-1-b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
        end else if (shift_en_i) begin
            if (dir_i) begin
                for (int g = 0; g < TOP; g++) begin
                    grp_q[g] <= grp_q[g+1];
                end
                grp_q[TOP] <= nib_rev;
            end else begin
                for (int g = 1; g <= TOP; g++) begin
                    grp_q[g] <= grp_q[g-1];
                end
                grp_q[0] <= nib_i;
            end
        end
    end

    assign sreg_o = grp_q;

    a_r2_low_entry: assert property (@(posedge clk) disable iff (rst)
        (shift_en_i && !dir_i) |=> (sreg_o[NIB_W-1:0] == $past(nib_i)));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(sreg_o));

endmodule

// File: rtl/lcdseg_outstage.sv
module lcdseg_outstage
    import lcdseg_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int GROUPS = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_fall_i,
    input  logic [NIB_W*GROUPS-1:0]     sreg_i,
    input  frame_ctl_t                  ctl_i,
    output logic [2*NIB_W*GROUPS-1:0]   level_o
);
    localparam int OUTS = NIB_W * GROUPS;

    logic [OUTS-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (load_fall_i) begin
            latch_q <= sreg_i;
        end
    end

    for (genvar j = 0; j < OUTS; j++) begin : g_col
        drive_lvl_e lvl;
        assign lvl              = pick_level(latch_q[j], ctl_i);
        assign level_o[2*j +: 2] = lvl;
    end

    a_r8_latch_copy: assert property (@(posedge clk) disable iff (rst)
        load_fall_i |=> (latch_q == $past(sreg_i)));

    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !load_fall_i |=> $stable(latch_q));

    a_r10_blank_all_v1: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.blank_n |-> (level_o == '0));

endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
    import lcdseg_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int GROUPS = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_clk_i,
    input  logic [NIB_W-1:0]            nibble_i,
    input  logic                        load_i,
    input  logic                        dir_i,
    input  logic                        en_right_i,
    input  logic                        en_left_i,
    output logic                        en_right_o,
    output logic                        en_left_o,
    input  logic                        alt_i,
    input  logic                        blank_n_i,
    output logic [2*NIB_W*GROUPS-1:0]   level_o
);
    localparam int OUTS = NIB_W * GROUPS;

    logic            shift_fall;
    logic            load_fall;
    logic            accept;
    logic [OUTS-1:0] sreg;
    frame_ctl_t      ctl;

    assign ctl.alt     = alt_i;
    assign ctl.blank_n = blank_n_i;

    lcdseg_fall_det u_shift_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (shift_clk_i),
        .fall_o (shift_fall)
    );

    lcdseg_fall_det u_load_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (load_i),
        .fall_o (load_fall)
    );

    lcdseg_chain_ctl #(
        .GROUPS (GROUPS)
    ) u_chain (
        .clk          (clk),
        .rst          (rst),
        .dir_i        (dir_i),
        .load_fall_i  (load_fall),
        .shift_fall_i (shift_fall),
        .en_right_i   (en_right_i),
        .en_left_i    (en_left_i),
        .en_right_o   (en_right_o),
        .en_left_o    (en_left_o),
        .accept_o     (accept)
    );

    lcdseg_shifter #(
        .NIB_W  (NIB_W),
        .GROUPS (GROUPS)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (accept),
        .dir_i      (dir_i),
        .nib_i      (nibble_i),
        .sreg_o     (sreg)
    );

    lcdseg_outstage #(
        .NIB_W  (NIB_W),
        .GROUPS (GROUPS)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .load_fall_i (load_fall),
        .sreg_i      (sreg),
        .ctl_i       (ctl),
        .level_o     (level_o)
    );

    a_r3_unarmed_edge_ignored: assert property (@(posedge clk) disable iff (rst)
        (shift_fall && !accept) |=> $stable(sreg));

    a_r6_one_pass_pin_low: assert property (@(posedge clk) disable iff (rst)
        !(en_left_o == 1'b0 && en_right_o == 1'b0));

endmodule

// File: tb/lcdseg_driver_test.sv
module lcdseg_driver_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         shift_clk_i;
    logic [3:0]   nibble_i;
    logic         load_i;
    logic         dir_i;
    logic         en_right_i;
    logic         en_left_i;
    logic         en_right_o;
    logic         en_left_o;
    logic         alt_i;
    logic         blank_n_i;
    logic [159:0] level_o;

    int checks   = 0;
    int failures = 0;

    logic [3:0]  nibs [20];
    logic [79:0] img_a;
    logic [79:0] img_cur;

    always #10 clk = ~clk;

    lcdseg_driver uut (
        .clk         (clk),
        .rst         (rst),
        .shift_clk_i (shift_clk_i),
        .nibble_i    (nibble_i),
        .load_i      (load_i),
        .dir_i       (dir_i),
        .en_right_i  (en_right_i),
        .en_left_i   (en_left_i),
        .en_right_o  (en_right_o),
        .en_left_o   (en_left_o),
        .alt_i       (alt_i),
        .blank_n_i   (blank_n_i),
        .level_o     (level_o)
    );

    // Expected latch image after a full fill of nibs[] (R4, R5).
    function automatic logic [79:0] image(input logic d);
        logic [79:0] v = '0;
        for (int k = 0; k < 20; k++) begin
            for (int b = 0; b < 4; b++) begin
                if (!d) v[4*(19-k)+b]   = nibs[k][b];
                else    v[4*k+3-b]      = nibs[k][b];
            end
        end
        return v;
    endfunction

    // Expected level bus (R9, R10).
    function automatic logic [159:0] levels(input logic [79:0] img, input logic a, input logic bn);
        logic [159:0] v;
        for (int j = 0; j < 80; j++) begin
            if (!bn)      v[2*j +: 2] = 2'b00;
            else if (a)   v[2*j +: 2] = img[j] ? 2'b11 : 2'b10;
            else          v[2*j +: 2] = img[j] ? 2'b00 : 2'b01;
        end
        return v;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_lv(input string req, input logic [79:0] img, input logic a, input logic bn);
        logic [159:0] exp;
        alt_i     = a;
        blank_n_i = bn;
        #1;
        exp = levels(img, a, bn);
        checks++;
        if (level_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, level_o, exp);
        end
    endtask

    task automatic send_nib(input logic [3:0] n);
        nibble_i    = n;
        shift_clk_i = 1'b1;
        step();
        shift_clk_i = 1'b0;
        step();
    endtask

    task automatic pulse_load();
        load_i = 1'b1;
        step();
        load_i = 1'b0;
        step();
    endtask

    task automatic rand_nibs();
        for (int k = 0; k < 20; k++) nibs[k] = 4'($urandom());
    endtask

    // Fill with nibs[]; checks the one-cycle handoff on the passing pin (R7).
    task automatic fill_and_handoff(input string req);
        for (int k = 0; k < 19; k++) send_nib(nibs[k]);
        send_nib(nibs[19]);
        if (!dir_i) begin
            chk_bit({req, " pass low"}, en_left_o, 1'b0);
            chk_bit({req, " R6 idle side"}, en_right_o, 1'b1);
        end else begin
            chk_bit({req, " pass low"}, en_right_o, 1'b0);
            chk_bit({req, " R6 idle side"}, en_left_o, 1'b1);
        end
        step();
        chk_bit({req, " pass released"}, dir_i ? en_right_o : en_left_o, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; shift_clk_i = 1'b0; nibble_i = '0; load_i = 1'b0;
        dir_i = 1'b0; en_right_i = 1'b1; en_left_i = 1'b1;
        alt_i = 1'b0; blank_n_i = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk_lv("R1 reset levels", '0, 1'b0, 1'b1);
        chk_bit("R1 left out high", en_left_o, 1'b1);
        chk_bit("R1 right out high", en_right_o, 1'b1);

        // R3 clocks ignored while not armed (receiving pin high)
        for (int k = 0; k < 5; k++) send_nib(4'hF);
        pulse_load();
        chk_lv("R3 unarmed clocks ignored", '0, 1'b0, 1'b1);

        // R4 direction low fill, R7 handoff, R2 capture
        en_right_i = 1'b0;
        step();
        rand_nibs();
        nibs[0]  = 4'b0001;
        nibs[19] = 4'b1000;
        fill_and_handoff("R7 dir low");
        for (int k = 0; k < 3; k++) send_nib(4'hF);
        chk_bit("R7 spent pass stays high", en_left_o, 1'b1);
        pulse_load();
        img_a = image(1'b0);
        chk_lv("R4 dir low image, R7 extra ignored", img_a, 1'b0, 1'b1);
        chk_lv("R9 alt high", img_a, 1'b1, 1'b1);
        chk_bit("R4 first nibble bit0 on index 76", level_o[153:152] == 2'b11, 1'b1);
        chk_bit("R4 last nibble bit3 on index 3", level_o[7:6] == 2'b11, 1'b1);

        // R8 load disarms; receiving pin high keeps it disarmed
        en_right_i = 1'b1;
        pulse_load();
        for (int k = 0; k < 20; k++) send_nib(4'h5);
        pulse_load();
        chk_lv("R8 no re-arm while receive high", img_a, 1'b0, 1'b1);

        // R6 wrong pin: direction high, right input low, left high
        dir_i = 1'b1; en_right_i = 1'b0; en_left_i = 1'b1;
        pulse_load();
        for (int k = 0; k < 20; k++) send_nib(4'hA);
        pulse_load();
        chk_lv("R6 right input ignored when dir high", img_a, 1'b0, 1'b1);

        // R5 direction high fill; R8 latch holds while shifting
        en_left_i = 1'b0;
        step();
        rand_nibs();
        nibs[19] = 4'b0001;
        for (int k = 0; k < 10; k++) send_nib(nibs[k]);
        chk_lv("R8 latch holds during shift", img_a, 1'b1, 1'b1);
        for (int k = 10; k < 19; k++) send_nib(nibs[k]);
        send_nib(nibs[19]);
        chk_bit("R7 dir high pass low", en_right_o, 1'b0);
        chk_bit("R6 dir high left idle", en_left_o, 1'b1);
        step();
        chk_bit("R7 dir high pass released", en_right_o, 1'b1);
        pulse_load();
        img_cur = image(1'b1);
        chk_lv("R5 dir high image", img_cur, 1'b0, 1'b1);
        chk_bit("R5 last nibble bit0 on index 79", level_o[159:158] == 2'b00, 1'b1);

        // R10 blanking
        chk_lv("R10 blank alt low", img_cur, 1'b0, 1'b0);
        chk_lv("R10 blank alt high", img_cur, 1'b1, 1'b0);

        // Random rounds: R2 R4 R5 R7 R9 R10
        for (int r = 0; r < 8; r++) begin
            dir_i      = 1'($urandom());
            en_right_i = dir_i;
            en_left_i  = ~dir_i;
            pulse_load();
            step();
            rand_nibs();
            fill_and_handoff("R7 random");
            pulse_load();
            img_cur = image(dir_i);
            for (int c = 0; c < 4; c++) begin
                chk_lv(dir_i ? "R5 R9 random" : "R4 R9 random", img_cur,
                       1'($urandom()), 1'($urandom() % 4 != 0));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule